// File: doc/BRIEF.md
# Timer Clock Gating and Wakeup Controller

This block sits in front of an 8-bit auto-reload timer counter. It holds the timer's control/status register, which software reaches over a simple register bus. From that register it chooses what advances the counter: a 1 ms timebase tick, the CPU clock, or nothing. It then qualifies that choice with the chip's current power mode and drives one clock-enable output to the counter.

The counter reports its overflow and compare events to this block. Each event sets a sticky flag. Each flag, together with its own enable bit and the global interrupt mask, drives a dedicated interrupt request line. The block also tells the power controller whether a pending request may end the current low-power mode. Wakeup rights differ between the two events and between the low-power modes. The counter itself and its reload and compare registers live elsewhere.

Power mode codes on `pmode` are: 0 run, 1 slow, 2 wait, 3 active-halt, 4 halt. Codes 5 to 7 behave as halt.

Top module: `tmr_pwr_ctl`

## Requirements
- R1: While reset is asserted and right after it, the control/status register reads 0x00, the compare flag reads 0, and all six outputs are low.
- R2: A write to address 0 stores clock select from bits 4:3, overflow enable from bit 1 and compare enable from bit 0. Bits 7:5 always read 0 whatever was written. Bit 2 (the overflow flag) ignores writes. Address 0 reads `{3'b000, clock select, OVF, overflow enable, compare enable}`, and address 1 reads `{7'b0, compare flag}`.
- R3: In run mode, clock select 01 makes `cnt_en` follow `ms_tick`, 10 holds `cnt_en` high every cycle, and 00 or 11 hold it low.
- R4: In slow mode, `cnt_en` pulses for one cycle on every 32nd source tick of the selected clock. The tick counter restarts from zero whenever slow mode is left.
- R5: Wait mode gates the counter clock exactly as run mode does.
- R6: In halt (and codes 5 to 7), `cnt_en` stays low. In active-halt, `cnt_en` stays low unless clock select is 01 and overflow enable is 1; in that case it follows `ms_tick`.
- R7: `ovf_evt` sets OVF and `cmp_evt` sets the compare flag from the next cycle. An event wins over a clear in the same cycle.
- R8: A read of address 0 while OVF is set clears OVF from the next cycle. A read of address 1 likewise clears the compare flag.
- R9: `ovf_irq` is OVF AND overflow enable AND NOT `irq_mask`. `cmp_irq` is the compare flag AND compare enable AND NOT `irq_mask`.
- R10: In wait, each interrupt request is also raised on its wake line. In active-halt, only `ovf_irq` wakes, and only when clock select is 01. In run, slow and halt, no wake line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags on read) |
| addr | input | 1 | 0 control/status, 1 compare status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pmode | input | 3 | Power mode code |
| ms_tick | input | 1 | One-cycle 1 ms timebase pulse |
| ovf_evt | input | 1 | Counter overflow pulse |
| cmp_evt | input | 1 | Counter compare-match pulse |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks requests |
| cnt_en | output | 1 | Counter clock enable |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_wake | output | 1 | Overflow wakeup request |
| cmp_wake | output | 1 | Compare wakeup request |

## Verification
A wrong slow-mode prescaler count is visible only on `cnt_en`. The pulse arrives early or late by up to 32 source ticks, so the reference model must track the count across mode changes to catch a missing restart. A flag that is stuck, or that is cleared when it should not be, shows on `rdata` and on the request lines in the very next cycle. A corrupted enable or clock-select bit shows on the next read, and immediately on `cnt_en` or on the wake lines in active-halt.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int REG_W     = 8;
  localparam int CK_LSB    = 3;
  localparam int OVF_BIT   = 2;
  localparam int OVFIE_BIT = 1;
  localparam int CMPIE_BIT = 0;

  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_SLOW  = 3'd1,
    PM_WAIT  = 3'd2,
    PM_AHALT = 3'd3,
    PM_HALT  = 3'd4
  } pm_e;

  localparam logic [1:0] CK_OFF = 2'b00;
  localparam logic [1:0] CK_MS  = 2'b01;
  localparam logic [1:0] CK_CPU = 2'b10;

  typedef struct packed {
    logic [1:0] ck;
    logic       ovfie;
    logic       cmpie;
  } ctl_t;
endpackage

// File: rtl/tpc_regs.sv
module tpc_regs
  import tpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ovf_evt,
  input  logic             cmp_evt,
  output ctl_t             ctl,
  output logic             ovf_flag,
  output logic             cmp_flag,
  output logic [REG_W-1:0] rdata
);
  ctl_t ctl_nxt;
  logic ovf_nxt, cmp_nxt;
  logic wr_ctl;
  logic unused_wbits;

  assign wr_ctl       = wr_en && (addr == 1'b0);
  assign unused_wbits = &{1'b0, wdata[REG_W-1:CK_LSB+2], wdata[OVF_BIT]};

  always_comb begin
    ctl_nxt = ctl;
    if (wr_ctl) begin
      ctl_nxt.ck    = wdata[CK_LSB +: 2];
      ctl_nxt.ovfie = wdata[OVFIE_BIT];
      ctl_nxt.cmpie = wdata[CMPIE_BIT];
    end
    ovf_nxt = ovf_flag;
    if (rd_en && (addr == 1'b0)) ovf_nxt = 1'b0;
    if (ovf_evt)                 ovf_nxt = 1'b1;
    cmp_nxt = cmp_flag;
    if (rd_en && (addr == 1'b1)) cmp_nxt = 1'b0;
    if (cmp_evt)                 cmp_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ctl      <= ctl_nxt;
      ovf_flag <= ovf_nxt;
      cmp_flag <= cmp_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == 1'b0) begin
      rdata[CK_LSB +: 2] = ctl.ck;
      rdata[OVF_BIT]     = ovf_flag;
      rdata[OVFIE_BIT]   = ctl.ovfie;
      rdata[CMPIE_BIT]   = ctl.cmpie;
    end else begin
      rdata[0] = cmp_flag;
    end
  end
endmodule

// File: rtl/tpc_clkgate.sv
module tpc_clkgate
  import tpc_pkg::*;
#(
  parameter int PRESC_W = 5
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pmode,
  input  logic [1:0] ck,
  input  logic       ovfie,
  input  logic       ms_tick,
  output logic       cnt_en
);
  localparam logic [PRESC_W-1:0] PRESC_LAST = {PRESC_W{1'b1}};

  logic               src_tick;
  logic [PRESC_W-1:0] pre_q, pre_nxt;

  always_comb begin
    case (ck)
      CK_MS:   src_tick = ms_tick;
      CK_CPU:  src_tick = 1'b1;
      default: src_tick = 1'b0;
    endcase
  end

  always_comb begin
    if (pmode != PM_SLOW)  pre_nxt = '0;
    else if (src_tick)     pre_nxt = pre_q + 1'b1;
    else                   pre_nxt = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nxt;
  end

  always_comb begin
    case (pmode)
      PM_RUN, PM_WAIT: cnt_en = src_tick;
      PM_SLOW:         cnt_en = src_tick && (pre_q == PRESC_LAST);
      PM_AHALT:        cnt_en = src_tick && (ck == CK_MS) && ovfie;
      default:         cnt_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/tpc_irq.sv
module tpc_irq
  import tpc_pkg::*;
(
  input  logic [2:0] pmode,
  input  logic [1:0] ck,
  input  logic       ovfie,
  input  logic       cmpie,
  input  logic       ovf_flag,
  input  logic       cmp_flag,
  input  logic       irq_mask,
  output logic       ovf_irq,
  output logic       cmp_irq,
  output logic       ovf_wake,
  output logic       cmp_wake
);
  always_comb begin
    ovf_irq  = ovf_flag && ovfie && !irq_mask;
    cmp_irq  = cmp_flag && cmpie && !irq_mask;
    ovf_wake = 1'b0;
    cmp_wake = 1'b0;
    case (pmode)
      PM_WAIT: begin
        ovf_wake = ovf_irq;
        cmp_wake = cmp_irq;
      end
      PM_AHALT: ovf_wake = ovf_irq && (ck == CK_MS);
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_pwr_ctl.sv
module tmr_pwr_ctl
  import tpc_pkg::*;
#(
  parameter int PRESC_W = 5
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [2:0]       pmode,
  input  logic             ms_tick,
  input  logic             ovf_evt,
  input  logic             cmp_evt,
  input  logic             irq_mask,
  output logic             cnt_en,
  output logic             ovf_irq,
  output logic             cmp_irq,
  output logic             ovf_wake,
  output logic             cmp_wake
);
  ctl_t       ctl;
  logic [1:0] ctl_ck;
  logic       ovf_flag, cmp_flag;

  assign ctl_ck = ctl.ck;

  tpc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .ctl(ctl),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .rdata(rdata)
  );

  tpc_clkgate #(.PRESC_W(PRESC_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .pmode(pmode), .ck(ctl.ck),
    .ovfie(ctl.ovfie), .ms_tick(ms_tick), .cnt_en(cnt_en)
  );

  tpc_irq u_irq (
    .pmode(pmode), .ck(ctl.ck), .ovfie(ctl.ovfie), .cmpie(ctl.cmpie),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq_mask(irq_mask),
    .ovf_irq(ovf_irq), .cmp_irq(cmp_irq), .ovf_wake(ovf_wake),
    .cmp_wake(cmp_wake)
  );
endmodule

// File: rtl/tpc_chk.sv
module tpc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] rdata,
  input logic [2:0] pmode,
  input logic [1:0] ck,
  input logic       ovf_flag,
  input logic       ovf_evt,
  input logic       irq_mask,
  input logic       cnt_en,
  input logic       ovf_irq,
  input logic       cmp_irq,
  input logic       ovf_wake,
  input logic       cmp_wake
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 1'b0) |-> (rdata[7:5] == 3'b000)); // R2
  AST_OFF_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((ck == 2'b00) || (ck == 2'b11)) |-> !cnt_en); // R3
  AST_SLOW_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pmode == 3'd1) && cnt_en) |=> !cnt_en); // R4
  AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode >= 3'd4) |-> !cnt_en); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag); // R7
  AST_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 1'b0) && ovf_flag && !ovf_evt) |=> !ovf_flag); // R8
  AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> (!ovf_irq && !cmp_irq)); // R9
  AST_HALT_NOWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode >= 3'd4) |-> (!ovf_wake && !cmp_wake)); // R10
endmodule

bind tmr_pwr_ctl tpc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .pmode(pmode), .ck(ctl_ck), .ovf_flag(ovf_flag), .ovf_evt(ovf_evt),
  .irq_mask(irq_mask), .cnt_en(cnt_en), .ovf_irq(ovf_irq),
  .cmp_irq(cmp_irq), .ovf_wake(ovf_wake), .cmp_wake(cmp_wake)
);

// File: tb/sim_tmr_pwr_ctl.sv
module sim_tmr_pwr_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] pmode = 3'd0;
  logic       ms_tick = 1'b0, ovf_evt = 1'b0, cmp_evt = 1'b0, irq_mask = 1'b0;
  logic       cnt_en, ovf_irq, cmp_irq, ovf_wake, cmp_wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  int m_ck = 0, m_pre = 0;
  bit m_ovfie = 0, m_cmpie = 0, m_ovf = 0, m_cmp = 0;

  always #10 clk = ~clk;

  tmr_pwr_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pmode(pmode), .ms_tick(ms_tick),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .irq_mask(irq_mask),
    .cnt_en(cnt_en), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq),
    .ovf_wake(ovf_wake), .cmp_wake(cmp_wake)
  );

  function automatic bit src_now();
    if (m_ck == 1) return ms_tick;
    if (m_ck == 2) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ck = 0; m_pre = 0; m_ovfie = 0; m_cmpie = 0; m_ovf = 0; m_cmp = 0;
    end else begin
      if (pmode != 3'd1) m_pre = 0;
      else if (src_now()) m_pre = (m_pre + 1) % 32;
      if (rd_en && !addr) m_ovf = 0;
      if (rd_en && addr)  m_cmp = 0;
      if (ovf_evt) m_ovf = 1;
      if (cmp_evt) m_cmp = 1;
      if (wr_en && !addr) begin
        m_ck = int'(wdata[4:3]); m_ovfie = wdata[1]; m_cmpie = wdata[0];
      end
    end
  end

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit e_cnt, e_oi, e_ci, e_ow, e_cw;
    int e_rd;
    case (pmode)
      3'd0, 3'd2: e_cnt = src_now();
      3'd1:       e_cnt = src_now() && (m_pre == 31);
      3'd3:       e_cnt = src_now() && (m_ck == 1) && m_ovfie;
      default:    e_cnt = 1'b0;
    endcase
    e_oi = m_ovf && m_ovfie && !irq_mask;
    e_ci = m_cmp && m_cmpie && !irq_mask;
    e_ow = (pmode == 3'd2) ? e_oi : ((pmode == 3'd3) ? (e_oi && m_ck == 1) : 1'b0);
    e_cw = (pmode == 3'd2) ? e_ci : 1'b0;
    e_rd = addr ? int'(m_cmp) : (m_ck * 8 + int'(m_ovf) * 4 + int'(m_ovfie) * 2 + int'(m_cmpie));
    chk(int'(rdata),    e_rd,       tag, "rdata (R2)");
    chk(int'(cnt_en),   int'(e_cnt), tag, "cnt_en (R3)");
    chk(int'(ovf_irq),  int'(e_oi),  tag, "ovf_irq (R9)");
    chk(int'(cmp_irq),  int'(e_ci),  tag, "cmp_irq (R9)");
    chk(int'(ovf_wake), int'(e_ow),  tag, "ovf_wake (R10)");
    chk(int'(cmp_wake), int'(e_cw),  tag, "cmp_wake (R10)");
  endtask

  // inputs are set right after a falling edge; outputs sampled 5 ns later
  task automatic tick(input string tag);
    #5;
    compare(tag);
    @(negedge clk);
    wr_en = 0; rd_en = 0; ovf_evt = 0; cmp_evt = 0; ms_tick = 0;
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    wr_en = 1; addr = 0; wdata = d;
    tick(tag);
  endtask

  task automatic rd(input logic a, input string tag);
    rd_en = 1; addr = a;
    tick(tag);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) tick("R1");
    rst_n = 1;
    tick("R1");
    addr = 1; tick("R1");
    addr = 0;

    // R2: reserved and read-only bits
    wr(8'hFF, "R2");
    tick("R2");
    chk(int'(rdata), 8'h1B, "R2", "rdata after 0xFF write");
    wr(8'h04, "R2");
    tick("R2");
    chk(int'(rdata), 8'h00, "R2", "OVF not writable");

    // R3: clock selection in run mode
    wr(8'h08, "R3");
    for (int i = 0; i < 8; i++) begin ms_tick = i[0]; tick("R3"); end
    wr(8'h10, "R3");
    for (int i = 0; i < 4; i++) tick("R3");
    chk(int'(cnt_en), 1, "R3", "cpu select enable");
    wr(8'h18, "R3");
    for (int i = 0; i < 4; i++) begin ms_tick = 1; tick("R3"); end
    wr(8'h00, "R3");
    ms_tick = 1; tick("R3");

    // R4: slow mode divide by 32 with restart on exit
    wr(8'h10, "R4");
    pmode = 3'd1;
    for (int i = 0; i < 70; i++) tick("R4");
    pmode = 3'd0; tick("R4");
    pmode = 3'd1;
    for (int i = 0; i < 40; i++) tick("R4");
    wr(8'h08, "R4");
    for (int i = 0; i < 80; i++) begin ms_tick = (i % 3 == 0); tick("R4"); end
    pmode = 3'd0;

    // R5: wait mode same as run
    pmode = 3'd2;
    for (int i = 0; i < 6; i++) begin ms_tick = i[1]; tick("R5"); end
    wr(8'h10, "R5");
    tick("R5");
    chk(int'(cnt_en), 1, "R5", "wait keeps cpu clock");

    // R6: halt and active-halt gating
    pmode = 3'd4; tick("R6");
    chk(int'(cnt_en), 0, "R6", "halt stops");
    pmode = 3'd7; tick("R6");
    pmode = 3'd3; tick("R6");
    wr(8'h12, "R6");
    ms_tick = 1; tick("R6");
    wr(8'h08, "R6");
    ms_tick = 1; tick("R6");
    wr(8'h0A, "R6");
    ms_tick = 1; tick("R6");
    chk(int'(cnt_en), 1, "R6", "active-halt ms+ovfie runs");
    tick("R6");

    // R7 and R8: flag set, clear on read, event priority
    pmode = 3'd0;
    wr(8'h13, "R7");
    ovf_evt = 1; tick("R7");
    tick("R7");
    chk(int'(ovf_irq), 1, "R7", "ovf flag raises request");
    rd(1'b0, "R8");
    tick("R8");
    chk(int'(rdata[2]), 0, "R8", "OVF cleared by read");
    ovf_evt = 1; tick("R7");
    rd_en = 1; addr = 0; ovf_evt = 1; tick("R7");
    tick("R7");
    chk(int'(rdata[2]), 1, "R7", "event beats read clear");
    cmp_evt = 1; tick("R7");
    addr = 1; tick("R7");
    rd(1'b1, "R8");
    tick("R8");
    chk(int'(rdata), 0, "R8", "compare flag cleared by read");
    addr = 0;

    // R9: enables and mask
    ovf_evt = 1; cmp_evt = 1; tick("R9");
    irq_mask = 1; tick("R9");
    irq_mask = 0; wr(8'h11, "R9");
    tick("R9");
    wr(8'h12, "R9");
    tick("R9");

    // R10: wakeup rights by mode
    wr(8'h0B, "R10");
    for (int m = 0; m < 6; m++) begin pmode = 3'(m); tick("R10"); end
    wr(8'h13, "R10");
    for (int m = 0; m < 6; m++) begin pmode = 3'(m); tick("R10"); end
    pmode = 3'd2; irq_mask = 1; tick("R10");
    irq_mask = 0;

    // mixed traffic against the reference model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 40 == 0) pmode = 3'($urandom % 6);
      if ($urandom % 25 == 0) begin wr_en = 1; wdata = 8'($urandom); end
      else if ($urandom % 20 == 0) rd_en = 1;
      addr     = ($urandom % 4 == 0);
      ms_tick  = ($urandom % 3 == 0);
      ovf_evt  = ($urandom % 30 == 0);
      cmp_evt  = ($urandom % 30 == 0);
      irq_mask = ($urandom % 8 == 0);
      tick("R4");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule